// File: doc/BRIEF.md
# Single-Connection TCP Responder

This block is the TCP control engine of a very small embedded web server. An upstream parser hands it one inbound segment at a time as a descriptor: ports, sequence and acknowledgement numbers, flags, window, checksum field, payload length, and a partial ones-complement sum covering the pseudo-header and payload. The block verifies that segment's checksum and tracks one client-initiated connection. Each reply it produces leaves as an outbound descriptor for a downstream framer: flags, sequence and acknowledgement numbers, window, length, checksum, and a payload-select code that tells the framer whether to attach the application's response bytes.

The connection only ever starts from a client SYN. Once the handshake is complete, a single data-bearing segment is taken as the whole request. Its length is handed to the application through a request handshake. The block then sends three segments in fixed order: a bare ACK, one data segment carrying the application's response, and a FIN. Teardown accepts the client's FIN and the acknowledgement of the block's own FIN in either order, or both in one segment, and then returns to listening. Nothing is retransmitted and no timer runs; the client handles loss.

All three streams use valid/ready. On every stream the source holds its valid signal and its fields stable until the handshake cycle. While an outbound segment is waiting, the block lowers `rx_ready`, so inbound segments back up behind a stalled transmitter. `rsp_ready` is raised only in the cycle in which the data segment is transferred on the transmit port.

Top module: `tcp_lite_responder`

## Requirements
- R1: After reset, `tx_valid`, `app_req_valid` and `rsp_ready` are 0 and `rx_ready` is 1.
- R2: While listening, a segment with SYN set (flag bit 1) and ACK clear (flag bit 4), addressed to `LOCAL_PORT`, with a valid checksum, yields one outbound segment. It has flags 0x12, sequence `ISS`, acknowledgement equal to the received sequence plus 1, the ports swapped, length 0 and select 0.
- R3: An inbound segment is discarded with no output and no state change if any of these holds: its checksum is invalid, its destination port is not `LOCAL_PORT`, or (once a connection is open) its source port differs from the client's or its sequence differs from the next expected one. An inbound checksum is valid when the folded 16-bit ones-complement sum of the ten header words (including the checksum field, with data offset 5 and urgent 0) plus `rx_psum` equals 0xFFFF.
- R4: A SYN arriving while a connection is open is ignored.
- R5: The handshake completes only on an ACK whose acknowledgement number is `ISS`+1 and whose sequence is the expected one; a wrong acknowledgement is ignored.
- R6: A data-bearing ACK segment received after the handshake raises `app_req_valid` with its length, held until `app_req_ready`. It also yields a bare ACK (flags 0x10) with sequence `ISS`+1 and acknowledgement equal to the request's sequence plus its length, modulo 2^32.
- R7: After that ACK, a response offered on `rsp_*` yields a data segment with flags 0x18, sequence `ISS`+1, length `rsp_len` and select 1. `rsp_ready` is asserted in the same cycle as that segment's transfer.
- R8: The data segment is followed by a FIN segment with flags 0x11 and sequence `ISS`+1+`rsp_len`.
- R9: A client FIN is answered with an ACK (flags 0x10) acknowledging the FIN's sequence plus its length plus 1. After both the client FIN and the acknowledgement of the block's FIN (acknowledgement number `ISS`+2+`rsp_len`) have arrived, in either order, the block listens again and accepts a new SYN.
- R10: `tx_csum` is the bitwise complement of the folded ones-complement sum of the outbound header words (checksum word taken as 0), plus `rsp_psum` for data segments only.
- R11: While `tx_valid` is high and `tx_ready` low, all transmit fields hold, and `rx_ready` is low whenever `tx_valid` is high.
- R12: Every outbound segment carries source port `LOCAL_PORT`, the client's port as destination, and window `WINDOW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Inbound segment descriptor valid |
| rx_ready | output | 1 | Block can take an inbound segment |
| rx_sport | input | 16 | Inbound source port |
| rx_dport | input | 16 | Inbound destination port |
| rx_seq | input | 32 | Inbound sequence number |
| rx_ack | input | 32 | Inbound acknowledgement number |
| rx_flags | input | 6 | Inbound flags, FIN=bit0 SYN=bit1 RST=bit2 PSH=bit3 ACK=bit4 URG=bit5 |
| rx_win | input | 16 | Inbound window field |
| rx_csum | input | 16 | Inbound checksum field |
| rx_len | input | 16 | Inbound payload length in bytes |
| rx_psum | input | 16 | Folded sum of pseudo-header and payload |
| app_req_valid | output | 1 | Request available for the application |
| app_req_ready | input | 1 | Application takes the request |
| app_req_len | output | 16 | Request payload length |
| rsp_valid | input | 1 | Application response available |
| rsp_ready | output | 1 | Response consumed this cycle |
| rsp_len | input | 16 | Response payload length |
| rsp_psum | input | 16 | Folded sum of response payload |
| tx_valid | output | 1 | Outbound segment descriptor valid |
| tx_ready | input | 1 | Framer takes the outbound segment |
| tx_sport | output | 16 | Outbound source port |
| tx_dport | output | 16 | Outbound destination port |
| tx_seq | output | 32 | Outbound sequence number |
| tx_ack | output | 32 | Outbound acknowledgement number |
| tx_flags | output | 6 | Outbound flags, same bit order as rx_flags |
| tx_win | output | 16 | Outbound window |
| tx_len | output | 16 | Outbound payload length |
| tx_sel | output | 2 | Payload select: 0 none, 1 application response |
| tx_csum | output | 16 | Outbound checksum, pseudo-header excluded |

## Verification
The bench opens the first connection with a client sequence just below 2^32, so acknowledgement arithmetic that does not wrap would send the wrong numbers. It offers segments with a corrupted checksum, the wrong port, the wrong sequence, the wrong acknowledgement and a late SYN. A design that accepted any of these would emit an unexpected segment, or would later reply with shifted numbers or to the wrong port. It stalls the transmit port during the data segment, so a design that let fields drift, consumed the response early or took new input while stalled would be caught. Teardown is driven in both orders, so a design that waited for one fixed order would either hang in teardown or fail to answer the next SYN.

// File: rtl/tcpr_pkg.sv
package tcpr_pkg;

  typedef enum logic [3:0] {
    ST_LISTEN,
    ST_SYN_TX,
    ST_SYN_WAIT,
    ST_ESTAB,
    ST_ACK_TX,
    ST_DATA_TX,
    ST_FIN_TX,
    ST_LAST_ACK,
    ST_FINACK_TX
  } tcpr_state_e;

  localparam int FL_FIN = 0;
  localparam int FL_SYN = 1;
  localparam int FL_RST = 2;
  localparam int FL_PSH = 3;
  localparam int FL_ACK = 4;

  localparam logic [1:0] SEL_NONE = 2'd0;
  localparam logic [1:0] SEL_RESP = 2'd1;

  // ones-complement 16-bit add with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  // folded sum of the twenty-byte header (urgent pointer is zero)
  function automatic logic [15:0] hdr_sum(
    input logic [15:0] sport, input logic [15:0] dport,
    input logic [31:0] seq,   input logic [31:0] ack,
    input logic [5:0]  flags, input logic [15:0] win,
    input logic [15:0] csum);
    logic [15:0] acc;
    acc = oc_add(sport, dport);
    acc = oc_add(acc, seq[31:16]);
    acc = oc_add(acc, seq[15:0]);
    acc = oc_add(acc, ack[31:16]);
    acc = oc_add(acc, ack[15:0]);
    acc = oc_add(acc, {4'd5, 6'd0, flags});
    acc = oc_add(acc, win);
    acc = oc_add(acc, csum);
    return acc;
  endfunction

endpackage

// File: rtl/tcpr_rx_check.sv
module tcpr_rx_check
  import tcpr_pkg::*;
(
  input  logic [15:0] sport,
  input  logic [15:0] dport,
  input  logic [31:0] seq,
  input  logic [31:0] ack,
  input  logic [5:0]  flags,
  input  logic [15:0] win,
  input  logic [15:0] csum,
  input  logic [15:0] psum,
  output logic        csum_ok
);
  logic [15:0] total;

  always_comb begin
    total   = oc_add(hdr_sum(sport, dport, seq, ack, flags, win, csum), psum);
    csum_ok = (total == 16'hFFFF);
  end
endmodule

// File: rtl/tcpr_ctrl.sv
module tcpr_ctrl
  import tcpr_pkg::*;
#(
  parameter logic [15:0] LOCAL_PORT = 16'd80,
  parameter logic [31:0] ISS        = 32'h0A00_0000,
  parameter int          LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [15:0]      rx_sport,
  input  logic [15:0]      rx_dport,
  input  logic [31:0]      rx_seq,
  input  logic [31:0]      rx_ack,
  input  logic [5:0]       rx_flags,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             rx_ok,
  input  logic             tx_fire,
  input  logic [LEN_W-1:0] rsp_len,
  output tcpr_state_e      st,
  output logic [31:0]      snd_nxt,
  output logic [31:0]      rcv_nxt,
  output logic [15:0]      cport,
  output logic             app_req_valid,
  input  logic             app_req_ready,
  output logic [LEN_W-1:0] app_req_len
);
  localparam int PAD_W = 32 - LEN_W;

  logic rx_fire, port_ok, conn_ok, f_syn, f_ack, f_fin, ack_hit, req_set;
  logic fin_acked, peer_fin;

  always_comb begin
    rx_ready = (st == ST_LISTEN) || (st == ST_SYN_WAIT) ||
               (st == ST_ESTAB)  || (st == ST_LAST_ACK);
    rx_fire  = rx_valid && rx_ready && rx_ok;
    f_syn    = rx_flags[FL_SYN];
    f_ack    = rx_flags[FL_ACK];
    f_fin    = rx_flags[FL_FIN];
    port_ok  = (rx_dport == LOCAL_PORT);
    conn_ok  = port_ok && (rx_sport == cport) && (rx_seq == rcv_nxt);
    ack_hit  = f_ack && (rx_ack == snd_nxt);
    req_set  = (st == ST_ESTAB) && rx_fire && conn_ok && f_ack &&
               !f_syn && !f_fin && (rx_len != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_LISTEN;
      snd_nxt   <= ISS;
      rcv_nxt   <= '0;
      cport     <= '0;
      fin_acked <= 1'b0;
      peer_fin  <= 1'b0;
    end else begin
      unique case (st)
        ST_LISTEN:
          if (rx_fire && port_ok && f_syn && !f_ack) begin
            cport     <= rx_sport;
            rcv_nxt   <= rx_seq + 32'd1;
            snd_nxt   <= ISS;
            fin_acked <= 1'b0;
            peer_fin  <= 1'b0;
            st        <= ST_SYN_TX;
          end
        ST_SYN_TX:
          if (tx_fire) begin
            snd_nxt <= snd_nxt + 32'd1;
            st      <= ST_SYN_WAIT;
          end
        ST_SYN_WAIT:
          if (rx_fire && conn_ok && ack_hit && !f_syn && !f_fin)
            st <= ST_ESTAB;
        ST_ESTAB:
          if (req_set) begin
            rcv_nxt <= rcv_nxt + {{PAD_W{1'b0}}, rx_len};
            st      <= ST_ACK_TX;
          end
        ST_ACK_TX:
          if (tx_fire) st <= ST_DATA_TX;
        ST_DATA_TX:
          if (tx_fire) begin
            snd_nxt <= snd_nxt + {{PAD_W{1'b0}}, rsp_len};
            st      <= ST_FIN_TX;
          end
        ST_FIN_TX:
          if (tx_fire) begin
            snd_nxt <= snd_nxt + 32'd1;
            st      <= ST_LAST_ACK;
          end
        ST_LAST_ACK:
          if (rx_fire && conn_ok && !f_syn) begin
            if (f_fin && !peer_fin) begin
              rcv_nxt   <= rcv_nxt + {{PAD_W{1'b0}}, rx_len} + 32'd1;
              fin_acked <= fin_acked || ack_hit;
              st        <= ST_FINACK_TX;
            end else if (ack_hit) begin
              if (peer_fin) st <= ST_LISTEN;
              else          fin_acked <= 1'b1;
            end
          end
        ST_FINACK_TX:
          if (tx_fire) begin
            peer_fin <= 1'b1;
            st       <= fin_acked ? ST_LISTEN : ST_LAST_ACK;
          end
        default: st <= ST_LISTEN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_req_valid <= 1'b0;
      app_req_len   <= '0;
    end else if (req_set) begin
      app_req_valid <= 1'b1;
      app_req_len   <= rx_len;
    end else if (app_req_ready) begin
      app_req_valid <= 1'b0;
    end
  end

  // R6: a pending request holds its length until taken
  assert_app_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    app_req_valid && !app_req_ready |=> app_req_valid && $stable(app_req_len));

endmodule

// File: rtl/tcpr_tx_build.sv
module tcpr_tx_build
  import tcpr_pkg::*;
#(
  parameter logic [15:0] LOCAL_PORT = 16'd80,
  parameter logic [31:0] ISS        = 32'h0A00_0000,
  parameter logic [15:0] WINDOW     = 16'd4096,
  parameter int          LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tcpr_state_e      st,
  input  logic [31:0]      snd_nxt,
  input  logic [31:0]      rcv_nxt,
  input  logic [15:0]      cport,
  input  logic             rsp_valid,
  input  logic [LEN_W-1:0] rsp_len,
  input  logic [15:0]      rsp_psum,
  output logic             tx_valid,
  output logic [15:0]      tx_sport,
  output logic [15:0]      tx_dport,
  output logic [31:0]      tx_seq,
  output logic [31:0]      tx_ack,
  output logic [5:0]       tx_flags,
  output logic [15:0]      tx_win,
  output logic [LEN_W-1:0] tx_len,
  output logic [1:0]       tx_sel,
  output logic [15:0]      tx_csum
);
  logic [15:0] pay_sum;

  always_comb begin
    tx_valid = 1'b0;
    tx_flags = '0;
    tx_len   = '0;
    tx_sel   = SEL_NONE;
    pay_sum  = 16'h0000;
    tx_sport = LOCAL_PORT;
    tx_dport = cport;
    tx_seq   = snd_nxt;
    tx_ack   = rcv_nxt;
    tx_win   = WINDOW;
    unique case (st)
      ST_SYN_TX: begin
        tx_valid         = 1'b1;
        tx_flags[FL_SYN] = 1'b1;
        tx_flags[FL_ACK] = 1'b1;
      end
      ST_ACK_TX, ST_FINACK_TX: begin
        tx_valid         = 1'b1;
        tx_flags[FL_ACK] = 1'b1;
      end
      ST_DATA_TX: begin
        tx_valid         = rsp_valid;
        tx_flags[FL_ACK] = 1'b1;
        tx_flags[FL_PSH] = 1'b1;
        tx_len           = rsp_len;
        tx_sel           = SEL_RESP;
        pay_sum          = rsp_psum;
      end
      ST_FIN_TX: begin
        tx_valid         = 1'b1;
        tx_flags[FL_FIN] = 1'b1;
        tx_flags[FL_ACK] = 1'b1;
      end
      default: tx_valid = 1'b0;
    endcase
    tx_csum = ~oc_add(hdr_sum(tx_sport, tx_dport, tx_seq, tx_ack, tx_flags,
                              tx_win, 16'h0000), pay_sum);
  end

  // R2: any SYN the block emits opens at the initial sequence number
  assert_synack_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_flags[FL_SYN] |-> tx_seq == ISS);

endmodule

// File: rtl/tcp_lite_responder.sv
module tcp_lite_responder
  import tcpr_pkg::*;
#(
  parameter logic [15:0] LOCAL_PORT = 16'd80,
  parameter logic [31:0] ISS        = 32'h0A00_0000,
  parameter logic [15:0] WINDOW     = 16'd4096,
  parameter int          LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [15:0]      rx_sport,
  input  logic [15:0]      rx_dport,
  input  logic [31:0]      rx_seq,
  input  logic [31:0]      rx_ack,
  input  logic [5:0]       rx_flags,
  input  logic [15:0]      rx_win,
  input  logic [15:0]      rx_csum,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [15:0]      rx_psum,
  output logic             app_req_valid,
  input  logic             app_req_ready,
  output logic [LEN_W-1:0] app_req_len,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [LEN_W-1:0] rsp_len,
  input  logic [15:0]      rsp_psum,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [15:0]      tx_sport,
  output logic [15:0]      tx_dport,
  output logic [31:0]      tx_seq,
  output logic [31:0]      tx_ack,
  output logic [5:0]       tx_flags,
  output logic [15:0]      tx_win,
  output logic [LEN_W-1:0] tx_len,
  output logic [1:0]       tx_sel,
  output logic [15:0]      tx_csum
);
  tcpr_state_e st;
  logic [31:0] snd_nxt, rcv_nxt;
  logic [15:0] cport;
  logic        rx_ok, tx_fire;

  assign tx_fire   = tx_valid && tx_ready;
  assign rsp_ready = tx_fire && (st == ST_DATA_TX);

  tcpr_rx_check u_rx_check (
    .sport(rx_sport), .dport(rx_dport), .seq(rx_seq), .ack(rx_ack),
    .flags(rx_flags), .win(rx_win), .csum(rx_csum), .psum(rx_psum),
    .csum_ok(rx_ok)
  );

  tcpr_ctrl #(.LOCAL_PORT(LOCAL_PORT), .ISS(ISS), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_sport(rx_sport), .rx_dport(rx_dport), .rx_seq(rx_seq), .rx_ack(rx_ack),
    .rx_flags(rx_flags), .rx_len(rx_len), .rx_ok(rx_ok),
    .tx_fire(tx_fire), .rsp_len(rsp_len),
    .st(st), .snd_nxt(snd_nxt), .rcv_nxt(rcv_nxt), .cport(cport),
    .app_req_valid(app_req_valid), .app_req_ready(app_req_ready),
    .app_req_len(app_req_len)
  );

  tcpr_tx_build #(.LOCAL_PORT(LOCAL_PORT), .ISS(ISS), .WINDOW(WINDOW),
                  .LEN_W(LEN_W)) u_tx_build (
    .clk(clk), .rst_n(rst_n),
    .st(st), .snd_nxt(snd_nxt), .rcv_nxt(rcv_nxt), .cport(cport),
    .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_psum(rsp_psum),
    .tx_valid(tx_valid), .tx_sport(tx_sport), .tx_dport(tx_dport),
    .tx_seq(tx_seq), .tx_ack(tx_ack), .tx_flags(tx_flags), .tx_win(tx_win),
    .tx_len(tx_len), .tx_sel(tx_sel), .tx_csum(tx_csum)
  );

  // R11: a stalled outbound segment does not change
  assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid &&
      $stable({tx_seq, tx_ack, tx_flags, tx_len, tx_sel, tx_csum, tx_dport}));

  // R11: no inbound segment is taken while one is waiting to go out
  assert_rx_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);

  // R7: the response is consumed only with the data segment's transfer
  assert_rsp_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> tx_valid && tx_ready && tx_sel == SEL_RESP && tx_len == rsp_len);

endmodule

// File: tb/test_tcp_lite_responder.sv
module test_tcp_lite_responder;
  localparam logic [15:0] LPORT = 16'd80;
  localparam logic [31:0] ISS   = 32'h0A00_0000;
  localparam logic [15:0] WIN   = 16'd4096;

  typedef struct packed {
    logic [15:0] sport;
    logic [15:0] dport;
    logic [31:0] seq;
    logic [31:0] ack;
    logic [5:0]  flags;
    logic [15:0] win;
    logic [15:0] len;
    logic [1:0]  sel;
    logic [15:0] csum;
  } seg_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_ready;
  logic [15:0] rx_sport = '0, rx_dport = '0, rx_win = '0, rx_csum = '0, rx_len = '0, rx_psum = '0;
  logic [31:0] rx_seq = '0, rx_ack = '0;
  logic [5:0]  rx_flags = '0;
  logic app_req_valid, app_req_ready = 1'b0;
  logic [15:0] app_req_len;
  logic rsp_valid = 1'b0, rsp_ready;
  logic [15:0] rsp_len = '0, rsp_psum = '0;
  logic tx_valid, tx_ready = 1'b1;
  logic [15:0] tx_sport, tx_dport, tx_win, tx_len, tx_csum;
  logic [31:0] tx_seq, tx_ack;
  logic [5:0]  tx_flags;
  logic [1:0]  tx_sel;

  int checks = 0, bad = 0;
  seg_t  exp_q[$];
  string tag_q[$];
  string cur_tag = "R3";

  always #4 clk = ~clk;

  tcp_lite_responder i_tcp_lite_responder (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_sport(rx_sport), .rx_dport(rx_dport),
    .rx_seq(rx_seq), .rx_ack(rx_ack), .rx_flags(rx_flags), .rx_win(rx_win),
    .rx_csum(rx_csum), .rx_len(rx_len), .rx_psum(rx_psum),
    .app_req_valid(app_req_valid), .app_req_ready(app_req_ready), .app_req_len(app_req_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_len(rsp_len), .rsp_psum(rsp_psum),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sport(tx_sport), .tx_dport(tx_dport),
    .tx_seq(tx_seq), .tx_ack(tx_ack), .tx_flags(tx_flags), .tx_win(tx_win),
    .tx_len(tx_len), .tx_sel(tx_sel), .tx_csum(tx_csum)
  );

  // folded ones-complement sum of header words plus an extra partial sum
  function automatic logic [15:0] fold_sum(input logic [15:0] sp, input logic [15:0] dp,
      input logic [31:0] sq, input logic [31:0] ak, input logic [5:0] fl,
      input logic [15:0] wn, input logic [15:0] cs, input logic [15:0] ps);
    int unsigned acc;
    acc = 32'(sp) + 32'(dp) + 32'(sq[31:16]) + 32'(sq[15:0]) + 32'(ak[31:16]) +
          32'(ak[15:0]) + 32'({4'd5, 6'd0, fl}) + 32'(wn) + 32'(cs) + 32'(ps);
    while ((acc >> 16) != 0) acc = (acc & 32'hFFFF) + (acc >> 16);
    return acc[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic expect_seg(input string tag, input logic [15:0] dp, input logic [31:0] sq,
      input logic [31:0] ak, input logic [5:0] fl, input logic [15:0] ln,
      input logic [1:0] sl, input logic [15:0] ps);
    seg_t e;
    e.sport = LPORT; e.dport = dp; e.seq = sq; e.ack = ak; e.flags = fl;
    e.win = WIN; e.len = ln; e.sel = sl;
    e.csum = ~fold_sum(LPORT, dp, sq, ak, fl, WIN, 16'h0, ps);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic send_seg(input string tag, input logic [15:0] sp, input logic [15:0] dp,
      input logic [31:0] sq, input logic [31:0] ak, input logic [5:0] fl,
      input logic [15:0] ln, input bit corrupt);
    cur_tag = tag;
    @(negedge clk);
    rx_sport = sp; rx_dport = dp; rx_seq = sq; rx_ack = ak; rx_flags = fl;
    rx_win = 16'd512; rx_len = ln; rx_psum = 16'h5A3C ^ ln;
    rx_csum = ~fold_sum(sp, dp, sq, ak, fl, 16'd512, 16'h0, rx_psum);
    if (corrupt) rx_csum = rx_csum ^ 16'h0001;
    rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic quiet(input string tag, input int n);
    repeat (n) @(negedge clk);
    check(exp_q.size() == 0, tag, $sformatf("pending outbound segments actual=%0d expected=0", exp_q.size()));
  endtask

  task automatic take_request(input string tag, input logic [15:0] ln);
    int waited = 0;
    @(negedge clk);
    while (!app_req_valid && waited < 20) begin @(negedge clk); waited++; end
    check(app_req_valid && app_req_len == ln, tag,
          $sformatf("request valid=%0b len actual=%0d expected=%0d", app_req_valid, app_req_len, ln));
    app_req_ready = 1'b1;
    @(negedge clk);
    app_req_ready = 1'b0;
  endtask

  task automatic give_response(input logic [15:0] ln, input logic [15:0] ps);
    @(negedge clk);
    rsp_len = ln; rsp_psum = ps; rsp_valid = 1'b1;
    #2;
    while (!rsp_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  // monitor: compares every transferred segment against the scoreboard
  seg_t held;
  bit   stalled = 1'b0;
  always @(negedge clk) begin
    seg_t act;
    #1;
    act = '{tx_sport, tx_dport, tx_seq, tx_ack, tx_flags, tx_win, tx_len, tx_sel, tx_csum};
    if (stalled) begin
      check(tx_valid && act == held, "R11",
            $sformatf("stalled segment changed actual=%h expected=%h", act, held));
      check(!rx_ready, "R11", $sformatf("rx_ready actual=%0b expected=0", rx_ready));
    end
    stalled = 1'b0;
    if (rst_n && tx_valid) begin
      if (!tx_ready) begin
        stalled = 1'b1;
        held = act;
      end else if (exp_q.size() == 0) begin
        check(1'b0, cur_tag, $sformatf("unexpected segment actual=%h expected=none", act));
      end else begin
        seg_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(act == e, t, $sformatf("segment actual=%h expected=%h", act, e));
      end
    end
  end

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", "run did not finish actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    // R1: idle outputs after reset
    check(!tx_valid && !app_req_valid && !rsp_ready && rx_ready, "R1",
          $sformatf("tx_valid=%0b app=%0b rsp_ready=%0b rx_ready=%0b expected 0 0 0 1",
                    tx_valid, app_req_valid, rsp_ready, rx_ready));
    rst_n = 1'b1;
    @(negedge clk);

    // R3: corrupted checksum and foreign port are dropped while listening
    send_seg("R3", 16'd5000, LPORT, 32'h100, 32'h0, 6'h02, 16'd0, 1'b1);
    send_seg("R3", 16'd5000, 16'd81, 32'h100, 32'h0, 6'h02, 16'd0, 1'b0);
    quiet("R3", 6);

    // R2: open from a client whose sequence wraps soon
    s = 32'hFFFF_FFF0;
    expect_seg("R2", 16'd5000, ISS, s + 32'd1, 6'h12, 16'd0, 2'd0, 16'h0);
    send_seg("R2", 16'd5000, LPORT, s, 32'h0, 6'h02, 16'd0, 1'b0);
    quiet("R2", 4);

    // R4: new SYNs while open are ignored
    send_seg("R4", 16'd5001, LPORT, 32'h77, 32'h0, 6'h02, 16'd0, 1'b0);
    send_seg("R4", 16'd5000, LPORT, s, 32'h0, 6'h02, 16'd0, 1'b0);
    quiet("R4", 4);

    // R5: wrong acknowledgement is ignored, right one completes the handshake
    send_seg("R5", 16'd5000, LPORT, s + 32'd1, ISS + 32'd5, 6'h10, 16'd0, 1'b0);
    send_seg("R5", 16'd5000, LPORT, s + 32'd1, ISS + 32'd1, 6'h10, 16'd0, 1'b0);
    quiet("R5", 4);

    // R3: request at the wrong sequence is dropped
    send_seg("R3", 16'd5000, LPORT, s + 32'd2, ISS + 32'd1, 6'h18, 16'd40, 1'b0);
    quiet("R3", 4);

    // R6: request across the 2^32 wrap
    expect_seg("R6", 16'd5000, ISS + 32'd1, s + 32'd41, 6'h10, 16'd0, 2'd0, 16'h0);
    send_seg("R6", 16'd5000, LPORT, s + 32'd1, ISS + 32'd1, 6'h18, 16'd40, 1'b0);
    take_request("R6", 16'd40);

    // R7 R8 R10 R12: data then FIN, with the transmit port stalled for a while
    expect_seg("R7", 16'd5000, ISS + 32'd1, s + 32'd41, 6'h18, 16'd100, 2'd1, 16'hBEEF);
    expect_seg("R8", 16'd5000, ISS + 32'd101, s + 32'd41, 6'h11, 16'd0, 2'd0, 16'h0);
    tx_ready = 1'b0;
    fork
      begin repeat (4) @(negedge clk); tx_ready = 1'b1; end
    join_none
    give_response(16'd100, 16'hBEEF);
    quiet("R8", 4);

    // R9: our FIN acknowledged first, then client FIN
    send_seg("R9", 16'd5000, LPORT, s + 32'd41, ISS + 32'd102, 6'h10, 16'd0, 1'b0);
    quiet("R9", 3);
    expect_seg("R9", 16'd5000, ISS + 32'd102, s + 32'd42, 6'h10, 16'd0, 2'd0, 16'h0);
    send_seg("R9", 16'd5000, LPORT, s + 32'd41, ISS + 32'd102, 6'h11, 16'd0, 1'b0);
    quiet("R9", 4);

    // R9: second connection, client FIN arrives before our FIN is acknowledged
    s = 32'h0000_1000;
    expect_seg("R9", 16'd6000, ISS, s + 32'd1, 6'h12, 16'd0, 2'd0, 16'h0);
    send_seg("R9", 16'd6000, LPORT, s, 32'h0, 6'h02, 16'd0, 1'b0);
    send_seg("R5", 16'd6000, LPORT, s + 32'd1, ISS + 32'd1, 6'h10, 16'd0, 1'b0);
    send_seg("R4", 16'd7000, LPORT, 32'h5, 32'h0, 6'h02, 16'd0, 1'b0);
    quiet("R4", 4);
    expect_seg("R6", 16'd6000, ISS + 32'd1, s + 32'd9, 6'h10, 16'd0, 2'd0, 16'h0);
    send_seg("R6", 16'd6000, LPORT, s + 32'd1, ISS + 32'd1, 6'h18, 16'd8, 1'b0);
    take_request("R6", 16'd8);
    expect_seg("R10", 16'd6000, ISS + 32'd1, s + 32'd9, 6'h18, 16'd12, 2'd1, 16'h0000);
    expect_seg("R8", 16'd6000, ISS + 32'd13, s + 32'd9, 6'h11, 16'd0, 2'd0, 16'h0);
    give_response(16'd12, 16'h0000);
    quiet("R8", 4);
    expect_seg("R9", 16'd6000, ISS + 32'd14, s + 32'd10, 6'h10, 16'd0, 2'd0, 16'h0);
    send_seg("R9", 16'd6000, LPORT, s + 32'd9, ISS + 32'd13, 6'h11, 16'd0, 1'b0);
    quiet("R9", 4);
    send_seg("R9", 16'd6000, LPORT, s + 32'd10, ISS + 32'd14, 6'h10, 16'd0, 1'b0);
    quiet("R9", 3);

    // R9 R12: listening again, a fresh client is served
    expect_seg("R12", 16'd7000, ISS, 32'd6, 6'h12, 16'd0, 2'd0, 16'h0);
    send_seg("R12", 16'd7000, LPORT, 32'd5, 32'h0, 6'h02, 16'd0, 1'b0);
    quiet("R12", 4);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule